// File: doc/BRIEF.md
# Inbound MSI Write Decoder with Partition Ownership Check

This block sits behind the inbound write path of a PCIe host bridge and turns message-signalled interrupt writes into interrupt trigger pulses. Each event carries a 64-bit address, a 16-bit data word and, optionally, the partition number of the requester. The source number is formed from address bits [19:4], OR-ed with the five low data bits. Sources at or beyond the configured source count are discarded. When the requester partition is supplied, the block fetches the vector entry of the source through a simple request/response port. It passes the event on only if the fetch succeeds and the partition field of the entry equals the requester.

Software can also inject an interrupt through a force register. The value written is used as the address, the data is taken as zero and no ownership check is made. When that forced event has been handled, whether it triggered or was discarded, a lock register is cleared. Every discarded event sets a sticky error flag. The source count and a base offset are loaded together. The count is clamped to the block's maximum, and the offset is added to the source number to give the global interrupt number that goes out with each trigger.

Top module: `msi_write_decoder`

## Requirements
- R1: The source number is address bits [19:4] OR-ed with data bits [4:0] (data zero-extended to 16 bits). Address bits above bit 19 and data bits above bit 4 have no effect.
- R2: An event whose source number is greater than or equal to the configured source count is discarded. A configuration write loads the count as min(cfg_count, MAX_SRC), with MAX_SRC = 2048 by default. The count is 0 after reset.
- R3: An event with msi_pe_en = 1 issues exactly one ent_req pulse with ent_idx equal to the source number. The event triggers only if the response has ent_rsp_err = 0 and ent_rsp_pe equal to msi_pe. Otherwise it is discarded.
- R4: An event with msi_pe_en = 0 issues no ent_req and triggers directly when in range.
- R5: Each accepted event gives exactly one single-cycle trig_valid pulse, with trig_src equal to the source number and trig_irq equal to (base + source) mod 2^IRQ_W. For an unchecked event, the pulse is visible in the cycle after the edge that follows the acceptance edge.
- R6: Every discarded event sets err_drop. err_drop stays at 1 until reset.
- R7: A frc_wr write queues an event with address frc_value, data 0 and no ownership check. A queued force event is served before msi traffic. msi_ready is 0 while an event is in progress or a force event is queued.
- R8: When a forced event completes, whether it triggers or is discarded, lock_q is cleared to zero. lock_wr loads lock_q from lock_wdata, and it takes precedence over the clear in the same cycle.
- R9: After reset, trig_valid, ent_req, err_drop and lock_q are 0 and msi_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load source count and base offset |
| cfg_count | input | 16 | Requested source count (clamped) |
| cfg_base | input | IRQ_W | Base offset added to source numbers |
| msi_valid | input | 1 | Inbound MSI write present |
| msi_ready | output | 1 | Decoder accepts an MSI write this cycle |
| msi_addr | input | ADDR_W | MSI write address |
| msi_data | input | 16 | MSI write data |
| msi_pe_en | input | 1 | Requester partition supplied (ownership check on) |
| msi_pe | input | PE_W | Requester partition number |
| frc_wr | input | 1 | Write to the force-interrupt register |
| frc_value | input | ADDR_W | Value written to the force register |
| lock_wr | input | 1 | Write to the lock register |
| lock_wdata | input | LOCK_W | Lock register write data |
| lock_q | output | LOCK_W | Lock register contents |
| ent_req | output | 1 | Vector entry fetch request pulse |
| ent_idx | output | SRC_W | Source number of the requested entry |
| ent_rsp_valid | input | 1 | Entry fetch response |
| ent_rsp_err | input | 1 | Entry fetch failed |
| ent_rsp_pe | input | PE_W | Partition field of the fetched entry |
| trig_valid | output | 1 | Single-cycle trigger pulse |
| trig_src | output | SRC_W | Source number of the trigger |
| trig_irq | output | IRQ_W | Global interrupt number (base + source) |
| err_drop | output | 1 | Sticky: an event was discarded |

## Verification
An MSI write and a force-register write can arrive in the same clock. The bench provokes this by raising msi_valid and frc_wr together while the decoder is idle. The MSI write must be accepted on that edge, with the force event held behind it, and msi_ready must drop in the next cycle. A behavioural reference model predicts the order of triggers as the MSI source followed by the forced source, and each trigger pulse is compared against the head of the model's queue. The lock register is checked again once the forced event has drained.

// File: rtl/msid_pkg.sv
package msid_pkg;

   localparam int SRCF_W     = 16;
   localparam int ADDR_SHIFT = 4;
   localparam int DLOW_W     = 5;
   localparam int ADDR_USED  = SRCF_W + ADDR_SHIFT;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_DECIDE = 2'd1,
      ST_WAIT   = 2'd2
   } eng_state_t;

   typedef struct packed {
      logic [SRCF_W-1:0] src;
      logic              chk;
      logic              frc;
   } evt_t;

   function automatic logic [SRCF_W-1:0] form_src(
      input logic [ADDR_USED-1:0] awin,
      input logic [DLOW_W-1:0]    dlow
   );
      return awin[ADDR_SHIFT +: SRCF_W] | {{(SRCF_W-DLOW_W){1'b0}}, dlow};
   endfunction

endpackage

// File: rtl/msid_srcmap.sv
module msid_srcmap
   import msid_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       data,
   output logic [SRCF_W-1:0] src
);

   generate
      if (ADDR_W < ADDR_USED) begin : g_bad_addr
         $error("msid_srcmap: ADDR_W too small for source field");
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{addr[ADDR_W-1:ADDR_USED], data[15:DLOW_W]};

   assign src = form_src(addr[ADDR_USED-1:0], data[DLOW_W-1:0]);

endmodule

// File: rtl/msid_cfg.sv
module msid_cfg
   import msid_pkg::*;
#(
   parameter int MAX_SRC = 2048,
   parameter int IRQ_W   = 20,
   parameter int CFG_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [CFG_W-1:0]    cfg_count,
   input  logic [IRQ_W-1:0]    cfg_base,
   input  logic [SRCF_W-1:0]   chk_src,
   output logic                in_range,
   output logic [IRQ_W-1:0]    base_q
);

   localparam int CNT_W  = $clog2(MAX_SRC + 1);
   localparam longint IN_MAX = (64'd1 << CFG_W) - 1;

   generate
      if (MAX_SRC < 1) begin : g_bad_max
         $error("msid_cfg: MAX_SRC must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_n;

   generate
      if (IN_MAX > MAX_SRC) begin : g_clamp
         always_comb begin
            if (32'(cfg_count) > 32'(MAX_SRC)) cnt_n = CNT_W'(MAX_SRC);
            else                               cnt_n = CNT_W'(cfg_count);
         end
      end else begin : g_pass
         always_comb cnt_n = CNT_W'(cfg_count);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         base_q <= '0;
      end else if (cfg_wr) begin
         cnt_q  <= cnt_n;
         base_q <= cfg_base;
      end
   end

   assign in_range = (32'(chk_src) < 32'(cnt_q));

   a_r2_count_clamped : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (32'(cnt_q) <= 32'(MAX_SRC)));

endmodule

// File: rtl/msid_force_slot.sv
module msid_force_slot #(
   parameter int ADDR_W = 64,
   parameter int LOCK_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frc_wr,
   input  logic [ADDR_W-1:0] frc_value,
   input  logic              take,
   input  logic              frc_done,
   input  logic              lock_wr,
   input  logic [LOCK_W-1:0] lock_wdata,
   output logic              pend,
   output logic [ADDR_W-1:0] val,
   output logic [LOCK_W-1:0] lock_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         val  <= '0;
      end else if (frc_wr) begin
         pend <= 1'b1;
         val  <= frc_value;
      end else if (take) begin
         pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        lock_q <= '0;
      else if (lock_wr)  lock_q <= lock_wdata;
      else if (frc_done) lock_q <= '0;
   end

   a_r8_lock_cleared : assert property (@(posedge clk) disable iff (!rst_n)
      (frc_done && !lock_wr) |=> (lock_q == '0));

   a_r8_lock_write : assert property (@(posedge clk) disable iff (!rst_n)
      lock_wr |=> (lock_q == $past(lock_wdata)));

endmodule

// File: rtl/msid_engine.sv
module msid_engine
   import msid_pkg::*;
#(
   parameter int PE_W  = 8,
   parameter int SRC_W = 11,
   parameter int IRQ_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  evt_t              start_evt,
   input  logic [PE_W-1:0]   start_pe,
   input  logic              in_range,
   input  logic [IRQ_W-1:0]  base,
   input  logic              rsp_valid,
   input  logic              rsp_err,
   input  logic [PE_W-1:0]   rsp_pe,
   output logic              idle,
   output logic [SRCF_W-1:0] cur_src,
   output logic              frc_done,
   output logic              ent_req,
   output logic [SRC_W-1:0]  ent_idx,
   output logic              trig_valid,
   output logic [SRC_W-1:0]  trig_src,
   output logic [IRQ_W-1:0]  trig_irq,
   output logic              err_drop
);

   generate
      if (SRC_W > SRCF_W) begin : g_bad_src
         $error("msid_engine: SRC_W wider than source field");
      end
   endgenerate

   eng_state_t      state_q, state_n;
   evt_t            evt_q;
   logic [PE_W-1:0] pe_q;
   logic            fire, drop, issue;

   always_comb begin
      state_n = state_q;
      fire    = 1'b0;
      drop    = 1'b0;
      issue   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) state_n = ST_DECIDE;
         end
         ST_DECIDE: begin
            if (!in_range) begin
               drop    = 1'b1;
               state_n = ST_IDLE;
            end else if (evt_q.chk) begin
               issue   = 1'b1;
               state_n = ST_WAIT;
            end else begin
               fire    = 1'b1;
               state_n = ST_IDLE;
            end
         end
         ST_WAIT: begin
            if (rsp_valid) begin
               if (rsp_err || (rsp_pe != pe_q)) drop = 1'b1;
               else                             fire = 1'b1;
               state_n = ST_IDLE;
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         evt_q      <= '0;
         pe_q       <= '0;
         ent_req    <= 1'b0;
         ent_idx    <= '0;
         trig_valid <= 1'b0;
         trig_src   <= '0;
         trig_irq   <= '0;
         err_drop   <= 1'b0;
      end else begin
         state_q    <= state_n;
         ent_req    <= issue;
         trig_valid <= fire;
         if (state_q == ST_IDLE && start) begin
            evt_q <= start_evt;
            pe_q  <= start_pe;
         end
         if (issue) ent_idx <= evt_q.src[SRC_W-1:0];
         if (fire) begin
            trig_src <= evt_q.src[SRC_W-1:0];
            trig_irq <= base + IRQ_W'(evt_q.src);
         end
         if (drop) err_drop <= 1'b1;
      end
   end

   assign idle     = (state_q == ST_IDLE);
   assign cur_src  = evt_q.src;
   assign frc_done = evt_q.frc && (fire || drop);

   a_r5_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      trig_valid |=> !trig_valid);

   a_r3_one_fetch : assert property (@(posedge clk) disable iff (!rst_n)
      ent_req |=> !ent_req);

   a_r6_err_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      err_drop |=> err_drop);

   a_r3_no_trig_on_fetch : assert property (@(posedge clk) disable iff (!rst_n)
      ent_req |-> !trig_valid);

endmodule

// File: rtl/msi_write_decoder.sv
module msi_write_decoder
   import msid_pkg::*;
#(
   parameter int MAX_SRC = 2048,
   parameter int ADDR_W  = 64,
   parameter int PE_W    = 8,
   parameter int IRQ_W   = 20,
   parameter int LOCK_W  = 64,
   localparam int SRC_W  = $clog2(MAX_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [15:0]       cfg_count,
   input  logic [IRQ_W-1:0]  cfg_base,
   input  logic              msi_valid,
   output logic              msi_ready,
   input  logic [ADDR_W-1:0] msi_addr,
   input  logic [15:0]       msi_data,
   input  logic              msi_pe_en,
   input  logic [PE_W-1:0]   msi_pe,
   input  logic              frc_wr,
   input  logic [ADDR_W-1:0] frc_value,
   input  logic              lock_wr,
   input  logic [LOCK_W-1:0] lock_wdata,
   output logic [LOCK_W-1:0] lock_q,
   output logic              ent_req,
   output logic [SRC_W-1:0]  ent_idx,
   input  logic              ent_rsp_valid,
   input  logic              ent_rsp_err,
   input  logic [PE_W-1:0]   ent_rsp_pe,
   output logic              trig_valid,
   output logic [SRC_W-1:0]  trig_src,
   output logic [IRQ_W-1:0]  trig_irq,
   output logic              err_drop
);

   generate
      if ((1 << SRC_W) != MAX_SRC) begin : g_bad_pow2
         $error("msi_write_decoder: MAX_SRC must be a power of two");
      end
      if (PE_W < 1 || IRQ_W < SRC_W) begin : g_bad_w
         $error("msi_write_decoder: PE_W or IRQ_W out of range");
      end
   endgenerate

   logic              frc_pend, frc_done, idle, rng_ok, start;
   logic [ADDR_W-1:0] frc_val, mux_addr;
   logic [15:0]       mux_data;
   logic [SRCF_W-1:0] new_src, cur_src;
   logic [IRQ_W-1:0]  base_q;
   evt_t              new_evt;

   assign msi_ready = idle && !frc_pend;
   assign start     = idle && (frc_pend || msi_valid);
   assign mux_addr  = frc_pend ? frc_val : msi_addr;
   assign mux_data  = frc_pend ? 16'h0 : msi_data;

   always_comb begin
      new_evt.src = new_src;
      new_evt.chk = !frc_pend && msi_pe_en;
      new_evt.frc = frc_pend;
   end

   msid_srcmap #(.ADDR_W(ADDR_W)) u_srcmap (
      .addr (mux_addr),
      .data (mux_data),
      .src  (new_src)
   );

   msid_cfg #(.MAX_SRC(MAX_SRC), .IRQ_W(IRQ_W), .CFG_W(16)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_count (cfg_count),
      .cfg_base  (cfg_base),
      .chk_src   (cur_src),
      .in_range  (rng_ok),
      .base_q    (base_q)
   );

   msid_force_slot #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W)) u_force (
      .clk        (clk),
      .rst_n      (rst_n),
      .frc_wr     (frc_wr),
      .frc_value  (frc_value),
      .take       (idle && frc_pend),
      .frc_done   (frc_done),
      .lock_wr    (lock_wr),
      .lock_wdata (lock_wdata),
      .pend       (frc_pend),
      .val        (frc_val),
      .lock_q     (lock_q)
   );

   msid_engine #(.PE_W(PE_W), .SRC_W(SRC_W), .IRQ_W(IRQ_W)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_evt  (new_evt),
      .start_pe   (msi_pe),
      .in_range   (rng_ok),
      .base       (base_q),
      .rsp_valid  (ent_rsp_valid),
      .rsp_err    (ent_rsp_err),
      .rsp_pe     (ent_rsp_pe),
      .idle       (idle),
      .cur_src    (cur_src),
      .frc_done   (frc_done),
      .ent_req    (ent_req),
      .ent_idx    (ent_idx),
      .trig_valid (trig_valid),
      .trig_src   (trig_src),
      .trig_irq   (trig_irq),
      .err_drop   (err_drop)
   );

   a_r2_fetch_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      ent_req |-> $past(rng_ok));

   a_r7_busy_not_ready : assert property (@(posedge clk) disable iff (!rst_n)
      ent_req |-> !msi_ready);

   a_r7_force_first : assert property (@(posedge clk) disable iff (!rst_n)
      (idle && frc_pend) |-> !msi_ready);

endmodule

// File: tb/msi_write_decoder_bench.sv
module msi_write_decoder_bench;

   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_count = '0;
   logic [19:0] cfg_base = '0;
   logic        msi_valid = 1'b0;
   logic        msi_ready;
   logic [63:0] msi_addr = '0;
   logic [15:0] msi_data = '0;
   logic        msi_pe_en = 1'b0;
   logic [7:0]  msi_pe = '0;
   logic        frc_wr = 1'b0;
   logic [63:0] frc_value = '0;
   logic        lock_wr = 1'b0;
   logic [63:0] lock_wdata = '0;
   logic [63:0] lock_q;
   logic        ent_req;
   logic [10:0] ent_idx;
   logic        ent_rsp_valid = 1'b0;
   logic        ent_rsp_err = 1'b0;
   logic [7:0]  ent_rsp_pe = '0;
   logic        trig_valid;
   logic [10:0] trig_src;
   logic [19:0] trig_irq;
   logic        err_drop;

   always #5 clk = ~clk;

   msi_write_decoder u_msi_write_decoder (.*);

   int  checks = 0;
   int  errors = 0;
   int  req_cnt = 0;
   bit  finished = 0;
   int  cnt_m = 0;
   int  base_m = 0;
   bit  err_m = 0;
   int  exp_q[$];
   logic [7:0] tbl_pe [2048];
   bit         tbl_err [2048];

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int src_of(input logic [63:0] a, input logic [15:0] d);
      return int'((a >> 4) & 64'hFFFF) | int'(d & 16'h1F);
   endfunction

   function automatic void model(input int src, input bit chk, input int pe);
      if (src >= cnt_m) err_m = 1;
      else if (chk && (tbl_err[src] || int'(tbl_pe[src]) != pe)) err_m = 1;
      else exp_q.push_back(src);
   endfunction

   always @(negedge clk) begin
      if (rst_n && trig_valid) begin
         if (exp_q.size() == 0) check(0, "R5 unexpected trigger", trig_irq, 0);
         else begin
            int s;
            s = exp_q.pop_front();
            check(int'(trig_src) == (s & 11'h7FF), "R5 trig_src", trig_src, s);
            check(int'(trig_irq) == ((base_m + s) & 20'hFFFFF), "R5 trig_irq",
                  trig_irq, (base_m + s) & 20'hFFFFF);
         end
      end
      if (rst_n && ent_req) req_cnt++;
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && ent_req) begin
            int idx;
            idx = int'(ent_idx);
            repeat (LAT - 1) @(negedge clk);
            ent_rsp_valid = 1'b1;
            ent_rsp_pe    = tbl_pe[idx];
            ent_rsp_err   = tbl_err[idx];
            @(negedge clk);
            ent_rsp_valid = 1'b0;
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cnt_m = 0; base_m = 0; err_m = 0; req_cnt = 0;
      exp_q.delete();
   endtask

   task automatic config_set(input int cnt, input int base);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_count = 16'(cnt); cfg_base = 20'(base);
      @(negedge clk);
      cfg_wr = 1'b0;
      cnt_m = (cnt > 2048) ? 2048 : cnt;
      base_m = base;
   endtask

   task automatic send(input logic [63:0] a, input logic [15:0] d, input bit en, input int pe);
      @(negedge clk);
      while (!msi_ready) @(negedge clk);
      msi_valid = 1'b1; msi_addr = a; msi_data = d; msi_pe_en = en; msi_pe = 8'(pe);
      model(src_of(a, d), en, pe);
      @(negedge clk);
      msi_valid = 1'b0;
   endtask

   task automatic force_write(input logic [63:0] v);
      @(negedge clk);
      frc_wr = 1'b1; frc_value = v;
      model(src_of(v, 16'h0), 0, 0);
      @(negedge clk);
      frc_wr = 1'b0;
   endtask

   task automatic lock_write(input logic [63:0] v);
      @(negedge clk);
      lock_wr = 1'b1; lock_wdata = v;
      @(negedge clk);
      lock_wr = 1'b0;
   endtask

   task automatic drain(input string req);
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
      check(err_drop == err_m, "R6 err_drop", err_drop, err_m);
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) begin
         tbl_pe[i] = 8'h00; tbl_err[i] = 0;
      end
      tbl_pe[10] = 8'd5;
      tbl_pe[12] = 8'd5; tbl_err[12] = 1;
      tbl_pe[9]  = 8'd77;

      do_reset();
      @(negedge clk);
      check(trig_valid == 0, "R9 trig_valid", trig_valid, 0);
      check(ent_req == 0,    "R9 ent_req", ent_req, 0);
      check(err_drop == 0,   "R9 err_drop", err_drop, 0);
      check(lock_q == 0,     "R9 lock_q", lock_q, 0);
      check(msi_ready == 1,  "R9 msi_ready", msi_ready, 1);

      // R1, R4, R5: unchecked event, latency
      config_set(40, 'h100);
      send(64'h200, 16'h3, 0, 0);
      @(negedge clk);
      check(trig_valid == 1, "R5 latency", trig_valid, 1);
      drain("R4 direct trigger");
      // R1: OR of fields, upper bits ignored
      send(64'h10, 16'h26, 0, 0);
      send(64'h1234_5678_0000_0070, 16'hFFE0, 0, 0);
      drain("R1 source formation");
      check(req_cnt == 0, "R4 no fetch", req_cnt, 0);

      // R2, R6: out of range
      send(64'h280, 16'h0, 0, 0);
      drain("R2 out of range");
      repeat (5) @(negedge clk);
      check(err_drop == 1, "R6 sticky", err_drop, 1);
      do_reset();
      @(negedge clk);
      check(err_drop == 0, "R6 cleared by reset", err_drop, 0);

      // R3: ownership check
      config_set(40, 'h100);
      send(64'hA0, 16'h0, 1, 5);
      @(negedge clk);
      check(msi_ready == 0, "R7 busy during fetch", msi_ready, 0);
      drain("R3 owner match");
      check(req_cnt == 1, "R3 fetch count", req_cnt, 1);
      send(64'hA0, 16'h0, 1, 6);
      drain("R3 owner mismatch");
      check(req_cnt == 2, "R3 fetch count", req_cnt, 2);
      do_reset();
      config_set(40, 'h100);
      send(64'hC0, 16'h0, 1, 5);
      drain("R3 fetch error");
      do_reset();
      config_set(40, 'h100);
      send(64'hC0, 16'h0, 0, 9);
      drain("R4 check off");
      check(req_cnt == 0, "R4 no fetch", req_cnt, 0);

      // R2: clamp and base wrap
      do_reset();
      config_set(5000, 'hFFF00);
      send(64'h7FF0, 16'h0, 0, 0);
      drain("R2 clamp top source");
      send(64'h8000, 16'h0, 0, 0);
      drain("R2 clamp drop");

      // R7, R8: force register
      do_reset();
      config_set(40, 'h100);
      lock_write(64'hABCD);
      check(lock_q == 64'hABCD, "R8 lock load", lock_q, 64'hABCD);
      force_write(64'h90);
      drain("R7 force trigger");
      check(req_cnt == 0, "R7 force no fetch", req_cnt, 0);
      check(lock_q == 0, "R8 lock cleared", lock_q, 0);
      lock_write(64'h1);
      force_write(64'h400);
      drain("R7 force drop");
      check(lock_q == 0, "R8 lock cleared on drop", lock_q, 0);

      // R7: collision of MSI and force write
      do_reset();
      config_set(40, 'h100);
      lock_write(64'h55);
      @(negedge clk);
      msi_valid = 1'b1; msi_addr = 64'h30; msi_data = 16'h0; msi_pe_en = 1'b0;
      frc_wr = 1'b1; frc_value = 64'h50;
      model(3, 0, 0);
      model(5, 0, 0);
      @(negedge clk);
      msi_valid = 1'b0; frc_wr = 1'b0;
      check(msi_ready == 0, "R7 ready low after collision", msi_ready, 0);
      drain("R7 collision order");
      check(lock_q == 0, "R8 lock after collision", lock_q, 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule